// File: doc/BRIEF.md
# Predicated Tree Reduction Engine

This block adds up the active elements of a short integer vector. A start pulse captures an element count, a flat vector of elements and a predicate mask. The engine then combines elements pairwise in a log-depth binary tree, one pair per clock cycle. It works only on private copies of the elements and the mask, so the caller's inputs are never changed.

When the left-hand side of a pair is inactive and the right-hand side is active, the engine does not move any data. It rewrites an index table so that the left position points at the right-hand element. Each activity flag is ORed upward through the tree. When the last pair is done, the engine pulses done for one cycle. The result is read from the element that index slot 0 points at, and a valid flag shows whether any element took part.

The outputs keep their values until the next accepted start. Addition wraps at the element width.

Top module: `pred_tree_reducer`

## Requirements
- R1: After reset, `done_o` and `sum_valid_o` are 0, `sum_o` is 0 and `mask_o` is all zeros.
- R2: When `done_o` is high, `sum_o` equals the sum, modulo 2^DATA_W, of every element k whose mask bit k is 1 and whose index k is below the effective count. Element k sits at bits [k*DATA_W +: DATA_W] of `elem_i`. Mask bits at or above the count have no effect on the sum.
- R3: When `done_o` is high, `mask_o` has every bit that was set in the captured mask, and possibly more. Bits at or above the effective count are exactly the captured input bits.
- R4: For a count of 2 or more, `done_o` rises N clock edges after the edge that accepts start. N is the sum, over steps s = 2, 4, 8, … while s/2 is below the count, of ceil(count/s). `done_o` stays high for exactly one cycle.
- R5: A start pulse is accepted only while the engine is idle. A start during a run, or in the cycle where `done_o` is high, is ignored. The result of the run in progress is kept, and no new run begins.
- R6: With a count of 0, the engine finishes on the edge after start with `sum_valid_o` = 0 and `sum_o` = 0. Whenever `sum_valid_o` is 0 at done, `sum_o` is 0.
- R7: With a count of 1, no tree pass runs and `done_o` rises on the edge after start. The sum is element 0 and is valid only if mask bit 0 is 1.
- R8: A count above MAX_VL is treated as MAX_VL.
- R9: A partial sum that exists only in the right half of a pair is carried to the result without moving data. This holds whether the active elements are all in the upper half, a single high element, or a sparse pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a reduction (taken only when idle) |
| vl_i | input | $clog2(MAX_VL+1) | Element count |
| elem_i | input | MAX_VL*DATA_W | Flat element vector, element k at [k*DATA_W +: DATA_W] |
| mask_i | input | MAX_VL | Predicate mask, bit k governs element k |
| sum_o | output | DATA_W | Reduced sum (0 when not valid) |
| sum_valid_o | output | 1 | At least one element was active |
| mask_o | output | MAX_VL | Final merged predicate copy |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the index-forwarding path. A subtree must be empty on its left side, so that its partial sum survives only through a rewritten index, and that forwarded index must then feed a later addition or become the final result. The directed stimulus creates this on purpose with masks whose active bits sit only in the upper half, with a single high bit, and with sparse alternating patterns. A batch of random counts and masks then crosses forwarding with accumulation at every tree level. Every run is compared against a plain modular sum computed in the bench.

// File: rtl/red_pkg.sv
package red_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } red_state_e;
endpackage

// File: rtl/red_seq.sv
module red_seq #(
    parameter int MAX_VL = 8,
    localparam int IW  = $clog2(MAX_VL),
    localparam int VLW = $clog2(MAX_VL + 1),
    localparam int SW  = IW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           adv_i,
    input  logic [VLW-1:0] vl_i,
    output logic [IW-1:0]  pos_o,
    output logic [SW-1:0]  partner_o,
    output logic           last_o
);
    typedef struct packed {
        logic [SW-1:0] pos;
        logic [SW-1:0] step;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [SW-1:0] vl_x;
    logic [SW-1:0] nxt;

    always_comb begin
        vl_x  = SW'(vl_i);
        nxt   = seq_q.pos + seq_q.step;
        seq_d = seq_q;
        if (load_i) begin
            seq_d.pos  = '0;
            seq_d.step = SW'(2);
        end else if (adv_i) begin
            if (nxt >= vl_x) begin
                seq_d.pos  = '0;
                seq_d.step = seq_q.step << 1;
            end else begin
                seq_d.pos = nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pos_o     = seq_q.pos[IW-1:0];
    assign partner_o = seq_q.pos + (seq_q.step >> 1);
    assign last_o    = (nxt >= vl_x) && (seq_q.step >= vl_x);

    // R4: every visited position lies below the count
    p_pos_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> (seq_q.pos < vl_x));
endmodule

// File: rtl/red_pair_unit.sv
module red_pair_unit #(
    parameter int MAX_VL = 8,
    parameter int DATA_W = 16,
    localparam int IW  = $clog2(MAX_VL),
    localparam int VLW = $clog2(MAX_VL + 1),
    localparam int SW  = IW + 2
) (
    input  logic [MAX_VL-1:0][DATA_W-1:0] elem_i,
    input  logic [MAX_VL-1:0]             mask_i,
    input  logic [MAX_VL-1:0][IW-1:0]     ix_i,
    input  logic [VLW-1:0]                vl_i,
    input  logic [IW-1:0]                 pos_i,
    input  logic [SW-1:0]                 partner_i,
    output logic [MAX_VL-1:0][DATA_W-1:0] elem_o,
    output logic [MAX_VL-1:0]             mask_o,
    output logic [MAX_VL-1:0][IW-1:0]     ix_o
);
    logic          in_range;
    logic [IW-1:0] ci;
    logic [IW-1:0] oi;
    logic          part_act;
    logic          here_act;

    always_comb begin
        in_range = partner_i < SW'(vl_i);
        ci       = ix_i[pos_i];
        oi       = in_range ? ix_i[partner_i[IW-1:0]] : '0;
        part_act = in_range && mask_i[oi];
        here_act = mask_i[ci];
        elem_o   = elem_i;
        mask_o   = mask_i;
        ix_o     = ix_i;
        if (here_act && part_act) begin
            elem_o[ci] = elem_i[ci] + elem_i[oi];
        end else if (part_act) begin
            ix_o[pos_i] = oi;
        end
        mask_o[ci] = here_act | part_act;
    end
endmodule

// File: rtl/pred_tree_reducer.sv
module pred_tree_reducer #(
    parameter int MAX_VL = 8,
    parameter int DATA_W = 16,
    localparam int IW  = $clog2(MAX_VL),
    localparam int VLW = $clog2(MAX_VL + 1),
    localparam int SW  = IW + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [VLW-1:0]           vl_i,
    input  logic [MAX_VL*DATA_W-1:0] elem_i,
    input  logic [MAX_VL-1:0]        mask_i,
    output logic [DATA_W-1:0]        sum_o,
    output logic                     sum_valid_o,
    output logic [MAX_VL-1:0]        mask_o,
    output logic                     done_o
);
    import red_pkg::*;

    typedef struct packed {
        red_state_e                   st;
        logic [MAX_VL-1:0][DATA_W-1:0] elem;
        logic [MAX_VL-1:0]             mask;
        logic [MAX_VL-1:0][IW-1:0]     ix;
        logic [VLW-1:0]                vl;
    } regs_t;

    regs_t r_d, r_q;

    logic [VLW-1:0]                vl_cap;
    logic [MAX_VL-1:0][DATA_W-1:0] elem_in;
    logic [MAX_VL-1:0][IW-1:0]     ix_ident;
    logic                          load;
    logic                          adv;
    logic [IW-1:0]                 pos;
    logic [SW-1:0]                 partner;
    logic                          last;
    logic [MAX_VL-1:0][DATA_W-1:0] elem_nx;
    logic [MAX_VL-1:0]             mask_nx;
    logic [MAX_VL-1:0][IW-1:0]     ix_nx;
    logic                          head_act;

    for (genvar k = 0; k < MAX_VL; k++) begin : g_unpack
        assign elem_in[k]  = elem_i[k*DATA_W +: DATA_W];
        assign ix_ident[k] = IW'(k);
    end

    assign vl_cap = (vl_i > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl_i;
    assign load   = (r_q.st == ST_IDLE) && start_i;
    assign adv    = (r_q.st == ST_RUN);

    red_seq #(.MAX_VL(MAX_VL)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .adv_i     (adv),
        .vl_i      (r_q.vl),
        .pos_o     (pos),
        .partner_o (partner),
        .last_o    (last)
    );

    red_pair_unit #(.MAX_VL(MAX_VL), .DATA_W(DATA_W)) u_pair (
        .elem_i    (r_q.elem),
        .mask_i    (r_q.mask),
        .ix_i      (r_q.ix),
        .vl_i      (r_q.vl),
        .pos_i     (pos),
        .partner_i (partner),
        .elem_o    (elem_nx),
        .mask_o    (mask_nx),
        .ix_o      (ix_nx)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.elem = elem_in;
                    r_d.mask = mask_i;
                    r_d.ix   = ix_ident;
                    r_d.vl   = vl_cap;
                    r_d.st   = (vl_cap < VLW'(2)) ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                r_d.elem = elem_nx;
                r_d.mask = mask_nx;
                r_d.ix   = ix_nx;
                if (last) r_d.st = ST_FIN;
            end
            ST_FIN:  r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign head_act    = (r_q.vl != '0) && r_q.mask[r_q.ix[0]];
    assign sum_valid_o = head_act;
    assign sum_o       = head_act ? r_q.elem[r_q.ix[0]] : '0;
    assign mask_o      = r_q.mask;
    assign done_o      = (r_q.st == ST_FIN);

    // R4: completion lasts a single cycle
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R3: merging never clears a predicate bit
    p_mask_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |=> ((r_q.mask & $past(r_q.mask)) == $past(r_q.mask)));
    // R5: captured count is frozen while not idle
    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> (r_q.vl == $past(r_q.vl)));
    // R7: short counts finish right after the accepting edge
    p_short_vl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_IDLE) && start_i && (vl_i < VLW'(2))) |=> done_o);
    // R8: the stored count never exceeds the maximum
    p_vl_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.vl <= VLW'(MAX_VL));
endmodule

// File: tb/pred_tree_reducer_test.sv
`timescale 1ns/1ps
module pred_tree_reducer_test;
    localparam int MAX_VL = 8;
    localparam int DATA_W = 16;
    localparam int VLW = $clog2(MAX_VL + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [VLW-1:0] vl_i = '0;
    logic [MAX_VL*DATA_W-1:0] elem_i = '0;
    logic [MAX_VL-1:0] mask_i = '0;
    logic [DATA_W-1:0] sum_o;
    logic sum_valid_o;
    logic [MAX_VL-1:0] mask_o;
    logic done_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pred_tree_reducer #(.MAX_VL(MAX_VL), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
        .elem_i(elem_i), .mask_i(mask_i), .sum_o(sum_o),
        .sum_valid_o(sum_valid_o), .mask_o(mask_o), .done_o(done_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int eff_vl(input int vl);
        return (vl > MAX_VL) ? MAX_VL : vl;
    endfunction

    function automatic int exp_lat(input int vl);
        int n = 0;
        for (int s = 2; (s / 2) < vl; s = s * 2) n += (vl + s - 1) / s;
        return n;
    endfunction

    // start a run, wait for done; returns edge count to done
    task automatic launch(input int vl, input logic [MAX_VL*DATA_W-1:0] el,
                          input logic [MAX_VL-1:0] m, output int lat);
        @(negedge clk);
        vl_i = VLW'(vl); elem_i = el; mask_i = m; start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        lat = 0;
        for (int w = 0; w < 200; w++) begin
            @(negedge clk);
            if (done_o) break;
            lat++;
        end
    endtask

    task automatic run_check(input string tag, input int vl,
                             input logic [MAX_VL*DATA_W-1:0] el,
                             input logic [MAX_VL-1:0] m);
        int lat;
        int ev;
        logic [DATA_W-1:0] es;
        logic ea;
        ev = eff_vl(vl);
        es = '0; ea = 1'b0;
        for (int k = 0; k < ev; k++) begin
            if (m[k]) begin
                es = es + el[k*DATA_W +: DATA_W];
                ea = 1'b1;
            end
        end
        launch(vl, el, m, lat);
        chk("R4", {tag, " done seen"}, 32'(done_o), 32'd1);
        chk("R4", {tag, " latency"}, 32'(lat), 32'(exp_lat(ev)));
        chk("R2", {tag, " sum"}, 32'(sum_o), 32'(es));
        chk("R2", {tag, " valid"}, 32'(sum_valid_o), 32'(ea));
        chk("R3", {tag, " mask superset"}, 32'(mask_o & m), 32'(m));
        for (int k = ev; k < MAX_VL; k++)
            chk("R3", {tag, " mask high bit"}, 32'(mask_o[k]), 32'(m[k]));
        @(negedge clk);
        chk("R4", {tag, " done one cycle"}, 32'(done_o), 32'd0);
    endtask

    function automatic logic [MAX_VL*DATA_W-1:0] pack(input int base, input int inc);
        logic [MAX_VL*DATA_W-1:0] v = '0;
        for (int k = 0; k < MAX_VL; k++) v[k*DATA_W +: DATA_W] = DATA_W'(base + inc * k);
        return v;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "done after reset", 32'(done_o), 32'd0);
        chk("R1", "valid after reset", 32'(sum_valid_o), 32'd0);
        chk("R1", "sum after reset", 32'(sum_o), 32'd0);
        chk("R1", "mask after reset", 32'(mask_o), 32'd0);
    endtask

    task automatic t_short();
        run_check("R6 vl0", 0, pack(5, 3), 8'hFF);
        chk("R6", "vl0 sum zero", 32'(sum_o), 32'd0);
        run_check("R7 vl1 on", 1, pack(9, 1), 8'h03);
        chk("R7", "vl1 sum", 32'(sum_o), 32'd9);
        run_check("R7 vl1 off", 1, pack(9, 1), 8'hFE);
        chk("R7", "vl1 valid off", 32'(sum_valid_o), 32'd0);
    endtask

    task automatic t_forward();
        run_check("R9 upper half", 8, pack(1, 1), 8'hF0);
        run_check("R9 single high", 7, pack(100, 7), 8'h40);
        run_check("R9 alternate", 8, pack(3, 2), 8'hAA);
        run_check("R9 sparse vl6", 6, pack(10, 10), 8'b0010_0110);
        run_check("R2 all on", 8, pack(1, 1), 8'hFF);
        chk("R2", "all on sum", 32'(sum_o), 32'd36);
        run_check("R2 high bits ignored", 5, pack(2, 0), 8'hE1);
    endtask

    task automatic t_wrap_clamp();
        logic [MAX_VL*DATA_W-1:0] v = '0;
        v[0 +: DATA_W] = 16'hFFFF;
        v[DATA_W +: DATA_W] = 16'hFFFF;
        run_check("R2 wrap", 2, v, 8'h03);
        chk("R2", "wrap sum", 32'(sum_o), 32'h0000FFFE);
        run_check("R8 clamp", 12, pack(4, 1), 8'hFF);
        chk("R8", "clamp latency sum", 32'(sum_o), 32'd60);
    endtask

    task automatic t_busy();
        int lat;
        @(negedge clk);
        vl_i = VLW'(8); elem_i = pack(1, 1); mask_i = 8'hFF; start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        vl_i = VLW'(3); elem_i = pack(50, 0); mask_i = 8'h07; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        for (int w = 0; w < 200; w++) begin
            if (done_o) break;
            @(negedge clk);
            lat++;
        end
        chk("R5", "busy start ignored sum", 32'(sum_o), 32'd36);
        // start during the done cycle
        vl_i = VLW'(2); elem_i = pack(7, 0); mask_i = 8'h03; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int w = 0; w < 4; w++) begin
            chk("R5", "no run after done-cycle start", 32'(done_o), 32'd0);
            @(negedge clk);
        end
        chk("R5", "result kept", 32'(sum_o), 32'd36);
    endtask

    task automatic t_random();
        for (int n = 0; n < 40; n++) begin
            logic [MAX_VL*DATA_W-1:0] v;
            int vl;
            for (int k = 0; k < MAX_VL; k++) v[k*DATA_W +: DATA_W] = DATA_W'($urandom);
            vl = $urandom_range(0, 10);
            run_check("R2 R9 random", vl, v, MAX_VL'($urandom));
        end
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_short();
        t_forward();
        t_wrap_clamp();
        t_busy();
        t_random();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL R4 watchdog expired before completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule